// File: doc/BRIEF.md
# Display RAM Host Address Controller

This block sits between a host bus and a bit-mapped display memory of 128 by 64 dots, organised as 16 byte-wide X columns and 64 Y lines, plus three extra Y lines that hold a segment area. It keeps the host's X and Y pointers and turns host read and write strobes into memory read enables, write enables and addresses. The memory array and the display scan logic are outside the block.

The host programs the pointers through a small register port and then streams data. After each access the pointers can step by themselves: X only, Y only, or X and Y together in raster order. Stepping can follow both reads and writes, or writes only, which suits read-modify-write loops. A mirror mode flips the column mapping, and a swap mode reverses the bit order of write data. Reads come back through a one-deep pipeline register, so the first read after the pointers are set returns old data (a dummy read).

A small state machine orders each access. In `ST_IDLE` a write strobe takes `IDLE_TO_WR` into `ST_WR_STEP`, and a read strobe with no write takes `IDLE_TO_RD` into `ST_RD_FETCH`. Each of those states returns to `ST_IDLE` after one cycle (`WR_DONE`, `RD_DONE`). With no strobe, `IDLE_HOLD` keeps the machine in `ST_IDLE`.

Top module: `dram_host_ctl`

## Requirements
- R1: After reset, ram_addr_x and ram_addr_y are 0, host_rdata is 0, and ram_we and ram_re are low.
- R2: A host_wr seen in idle raises ram_we for exactly that cycle, with the address in force before the strobe. A host_rd seen in idle with host_wr low raises ram_re for that cycle. Strobes in the one busy cycle that follows are ignored. Any pointer step becomes visible two cycles after the strobe.
- R3: reg_sel 0 loads the host X pointer from reg_wdata[3:0]. reg_sel 3 is the mode register, with bit 0 as mirror and bit 1 as swap. With mirror clear, ram_addr_x equals the host X value. With mirror set, it equals 15 minus that value.
- R4: reg_sel 1 loads Y bits [3:0] from reg_wdata[3:0], and reg_sel 2 loads Y bits [6:4] from reg_wdata[2:0]. Y values 64 to 66 address the segment area.
- R5: With swap set, ram_wdata is host_wdata bit-reversed, so host bit 0 lands in bit 7. With swap clear, it is host_wdata unchanged.
- R6: reg_sel 4 is the step control register, with bit 0 as X-step and bit 1 as Y-step. Setting 00 gives no stepping, 01 steps X only, 10 steps Y only, and 11 steps X with Y carry. The host X value wraps from 15 to 0, so under mirror the internal address runs downward from 15 to 0.
- R7: Y steps wrap from 63 to 0. With both step bits set, Y advances by one only on the access that wraps host X from 15 to 0.
- R8: Bit 2 of the step control register selects when stepping happens. At 0, reads and writes both step. At 1, only writes step, and reads leave the pointers unchanged.
- R9: A read presents on host_rdata the pipeline contents as they were at the strobe, and loads the pipeline from the current address. After a pointer set, the first read returns stale data, the second returns the addressed byte, and further reads return consecutive addresses.
- R10: A write to the step control register clears both the X and Y pointers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 X, 1 Y low, 2 Y high, 3 mode, 4 step control) |
| reg_wdata | input | 4 | Register write data |
| host_wr | input | 1 | Host data write strobe |
| host_rd | input | 1 | Host data read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read pipeline register |
| ram_addr_x | output | 4 | Memory column address |
| ram_addr_y | output | 7 | Memory line address |
| ram_we | output | 1 | Memory write enable |
| ram_re | output | 1 | Memory read enable (data expected the next cycle) |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data |

## Verification
The bench fills every one of the 1024 bytes of the main area using cooperative stepping, then reads all of them back. This catches a Y carry that fires on the wrong X value, which would skew the whole raster. It also catches a missing dummy read, which would shift every returned byte by one address. Directed runs walk the mirrored X pointer through its wrap, where a design that steps the internal address instead of the host value would climb past 15. They also cross the Y 63-to-0 boundary and check the segment-area load. The write-only timing mode is tested too: a design that steps on reads there would move the address between two reads. The bench also confirms that writing the step control register zeroes both pointers.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    // Access sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WR_STEP  = 2'd1,
        ST_RD_FETCH = 2'd2
    } dhc_state_e;

    // Register port selector codes.
    localparam logic [2:0] SEL_X    = 3'd0;
    localparam logic [2:0] SEL_YLO  = 3'd1;
    localparam logic [2:0] SEL_YHI  = 3'd2;
    localparam logic [2:0] SEL_MODE = 3'd3;
    localparam logic [2:0] SEL_STEP = 3'd4;

    localparam int REG_W = 4;
    localparam int YLO_W = 4;

endpackage

// File: rtl/dhc_bitswap.sv
module dhc_bitswap #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] rev;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = din[W-1-i];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/dhc_xy_counter.sv
module dhc_xy_counter import dhc_pkg::*; #(
    parameter int X_COLS  = 16,
    parameter int Y_LINES = 64,
    parameter int Y_SEG   = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ld_x,
    input  logic                               ld_ylo,
    input  logic                               ld_yhi,
    input  logic                               clr,
    input  logic [REG_W-1:0]                   din,
    input  logic                               step,
    input  logic                               sel_x,
    input  logic                               sel_y,
    output logic [$clog2(X_COLS)-1:0]          x_q,
    output logic [$clog2(Y_LINES+Y_SEG)-1:0]   y_q
);
    localparam int XW    = $clog2(X_COLS);
    localparam int YW    = $clog2(Y_LINES + Y_SEG);
    localparam int YHI_W = YW - YLO_W;
    localparam logic [XW-1:0] X_LAST = XW'(X_COLS - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(Y_LINES - 1);

    logic x_wrap;
    logic x_adv;
    logic y_adv;

    assign x_wrap = (x_q == X_LAST);
    assign x_adv  = step && sel_x;
    // Y carries from X only when both step bits are set.
    assign y_adv  = step && sel_y && (!sel_x || x_wrap);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            x_q <= '0;
        end else if (ld_x) begin
            x_q <= din[XW-1:0];
        end else if (x_adv) begin
            x_q <= x_wrap ? '0 : x_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            y_q <= '0;
        end else if (ld_ylo) begin
            y_q[YLO_W-1:0] <= din[YLO_W-1:0];
        end else if (ld_yhi) begin
            y_q[YW-1:YLO_W] <= din[YHI_W-1:0];
        end else if (y_adv) begin
            y_q <= (y_q >= Y_LAST) ? '0 : y_q + 1'b1;
        end
    end
endmodule

// File: rtl/dhc_seq.sv
module dhc_seq import dhc_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              wr_only,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic              step,
    output logic [DATA_W-1:0] pipe_q
);
    dhc_state_e state_q, state_d;

    // State register and read pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pipe_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RD_FETCH) begin
                pipe_q <= ram_rdata;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        ram_we  = 1'b0;
        ram_re  = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_wr) begin
                    ram_we  = 1'b1;
                    state_d = ST_WR_STEP;
                end else if (host_rd) begin
                    ram_re  = 1'b1;
                    state_d = ST_RD_FETCH;
                end
            end
            ST_WR_STEP: begin
                step    = 1'b1;
                state_d = ST_IDLE;
            end
            ST_RD_FETCH: begin
                step    = !wr_only;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dram_host_ctl.sv
module dram_host_ctl import dhc_pkg::*; #(
    parameter int X_COLS  = 16,
    parameter int Y_LINES = 64,
    parameter int Y_SEG   = 3,
    parameter int DATA_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [2:0]                        reg_sel,
    input  logic [REG_W-1:0]                  reg_wdata,
    input  logic                              host_wr,
    input  logic                              host_rd,
    input  logic [DATA_W-1:0]                 host_wdata,
    output logic [DATA_W-1:0]                 host_rdata,
    output logic [$clog2(X_COLS)-1:0]         ram_addr_x,
    output logic [$clog2(Y_LINES+Y_SEG)-1:0]  ram_addr_y,
    output logic                              ram_we,
    output logic                              ram_re,
    output logic [DATA_W-1:0]                 ram_wdata,
    input  logic [DATA_W-1:0]                 ram_rdata
);
    localparam int XW = $clog2(X_COLS);
    localparam int YW = $clog2(Y_LINES + Y_SEG);
    localparam logic [XW-1:0] X_LAST = XW'(X_COLS - 1);

    logic          mirror, swap;
    logic          inc_x, inc_y, wr_only;
    logic          step;
    logic [XW-1:0] x_host;
    logic [YW-1:0] y_host;
    logic          wr_x, wr_ylo, wr_yhi, wr_mode, wr_step;

    assign wr_x    = reg_we && (reg_sel == SEL_X);
    assign wr_ylo  = reg_we && (reg_sel == SEL_YLO);
    assign wr_yhi  = reg_we && (reg_sel == SEL_YHI);
    assign wr_mode = reg_we && (reg_sel == SEL_MODE);
    assign wr_step = reg_we && (reg_sel == SEL_STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror  <= 1'b0;
            swap    <= 1'b0;
            inc_x   <= 1'b0;
            inc_y   <= 1'b0;
            wr_only <= 1'b0;
        end else begin
            if (wr_mode) begin
                mirror <= reg_wdata[0];
                swap   <= reg_wdata[1];
            end
            if (wr_step) begin
                inc_x   <= reg_wdata[0];
                inc_y   <= reg_wdata[1];
                wr_only <= reg_wdata[2];
            end
        end
    end

    dhc_xy_counter #(
        .X_COLS (X_COLS),
        .Y_LINES(Y_LINES),
        .Y_SEG  (Y_SEG)
    ) i_xy (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_x  (wr_x),
        .ld_ylo(wr_ylo),
        .ld_yhi(wr_yhi),
        .clr   (wr_step),
        .din   (reg_wdata),
        .step  (step),
        .sel_x (inc_x),
        .sel_y (inc_y),
        .x_q   (x_host),
        .y_q   (y_host)
    );

    dhc_seq #(.DATA_W(DATA_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .wr_only  (wr_only),
        .ram_rdata(ram_rdata),
        .ram_we   (ram_we),
        .ram_re   (ram_re),
        .step     (step),
        .pipe_q   (host_rdata)
    );

    dhc_bitswap #(.W(DATA_W)) i_swap (
        .en  (swap),
        .din (host_wdata),
        .dout(ram_wdata)
    );

    // Mirror maps the host column onto the opposite end of the row.
    assign ram_addr_x = mirror ? (X_LAST - x_host) : x_host;
    assign ram_addr_y = y_host;
endmodule

// File: rtl/dram_host_ctl_chk.sv
module dram_host_ctl_chk #(
    parameter int XW     = 4,
    parameter int YW     = 7,
    parameter int DATA_W = 8,
    parameter int X_COLS = 16,
    parameter int Y_LINES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              ram_we,
    input logic              ram_re,
    input logic              step,
    input logic              inc_x,
    input logic              inc_y,
    input logic [XW-1:0]     x_host,
    input logic [YW-1:0]     y_host,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [DATA_W-1:0] host_rdata
);
    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R2
    AST_WE_BUSY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (!ram_we && !ram_re)); // R2
    AST_RE_BUSY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (!ram_we && !ram_re)); // R2
    AST_RDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_rdata) |-> $past(ram_re, 2)); // R9
    AST_WDATA_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($countones(ram_wdata) == $countones(host_wdata))); // R5
    AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc_x && !reg_we && x_host == XW'(X_COLS - 1)) |=> (x_host == '0)); // R6
    AST_Y_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc_y && !inc_x && !reg_we && y_host == YW'(Y_LINES - 1)) |=> (y_host == '0)); // R7
endmodule

bind dram_host_ctl dram_host_ctl_chk #(
    .XW     ($clog2(X_COLS)),
    .YW     ($clog2(Y_LINES + Y_SEG)),
    .DATA_W (DATA_W),
    .X_COLS (X_COLS),
    .Y_LINES(Y_LINES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .step      (step),
    .inc_x     (inc_x),
    .inc_y     (inc_y),
    .x_host    (x_host),
    .y_host    (y_host),
    .host_wdata(host_wdata),
    .ram_wdata (ram_wdata),
    .host_rdata(host_rdata)
);

// File: tb/test_dram_host_ctl.sv
module test_dram_host_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [3:0] reg_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [3:0] ram_addr_x;
    logic [6:0] ram_addr_y;
    logic       ram_we, ram_re;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dram_host_ctl i_dram_host_ctl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_addr_x(ram_addr_x), .ram_addr_y(ram_addr_y),
        .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    // Memory model: synchronous read, 16 columns by 67 lines.
    logic [7:0] mem [0:16*67-1];
    int         midx;
    assign midx = int'(ram_addr_y) * 16 + int'(ram_addr_x);
    always @(posedge clk) begin
        if (ram_we && midx < 16*67) mem[midx] <= ram_wdata;
        if (ram_re) ram_rdata <= (midx < 16*67) ? mem[midx] : 8'h00;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 7 + (k >> 4) * 3) ^ 8'h5A);
    endfunction

    task automatic reg_write(input logic [2:0] sel, input logic [3:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic hwrite(input logic [7:0] d, output int ax, output int ay,
                          output int wd, output int we);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = d;
        #1;
        ax = int'(ram_addr_x); ay = int'(ram_addr_y);
        wd = int'(ram_wdata); we = int'(ram_we);
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic hread(output int rd, output int ax, output int ay);
        @(negedge clk);
        rd = int'(host_rdata);
        host_rd = 1'b1;
        #1;
        ax = int'(ram_addr_x); ay = int'(ram_addr_y);
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ax, ay, wd, we, rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 addr_x", int'(ram_addr_x), 0);
        check("R1 addr_y", int'(ram_addr_y), 0);
        check("R1 rdata", int'(host_rdata), 0);
        check("R1 we_re", int'({ram_we, ram_re}), 0);

        // R5 swap off and on
        hwrite(8'h35, ax, ay, wd, we);
        check("R5 plain", wd, 8'h35);
        check("R2 we", we, 1);
        reg_write(3'd3, 4'b0010);
        hwrite(8'h01, ax, ay, wd, we);
        check("R5 swap 01", wd, 8'h80);
        hwrite(8'h35, ax, ay, wd, we);
        check("R5 swap 35", wd, 8'hAC);
        reg_write(3'd3, 4'b0000);

        // R4 segment-area Y load
        reg_write(3'd1, 4'h1);
        reg_write(3'd2, 4'h4);
        @(negedge clk);
        check("R4 y seg", int'(ram_addr_y), 65);

        // R10 step-control write clears pointers
        reg_write(3'd0, 4'd7);
        reg_write(3'd4, 4'b0001);
        @(negedge clk);
        check("R10 x cleared", int'(ram_addr_x), 0);
        check("R10 y cleared", int'(ram_addr_y), 0);

        // R3 R6 mirrored X stepping through the wrap
        reg_write(3'd3, 4'b0001);
        reg_write(3'd0, 4'd2);
        for (int i = 0; i < 16; i++) begin
            hwrite(8'h00, ax, ay, wd, we);
            check("R3 R6 mirror x", ax, 15 - ((2 + i) % 16));
            check("R6 x only y", ay, 0);
        end
        reg_write(3'd3, 4'b0000);

        // R6 R7 Y-only stepping across 63 -> 0
        reg_write(3'd4, 4'b0010);
        reg_write(3'd0, 4'd5);
        reg_write(3'd1, 4'hE);
        reg_write(3'd2, 4'h3);
        for (int i = 0; i < 3; i++) begin
            hwrite(8'h00, ax, ay, wd, we);
            check("R7 y wrap", ay, (62 + i) % 64);
            check("R6 y only x", ax, 5);
        end

        // R6 R7 R2 cooperative fill of the whole main area
        reg_write(3'd4, 4'b0011);
        for (int k = 0; k < 1024; k++) begin
            hwrite(pat(k), ax, ay, wd, we);
            check("R7 coop x", ax, k % 16);
            check("R7 coop y", ay, k / 16);
        end

        // R9 R8 readback with stepping on reads
        hread(rd, ax, ay);
        check("R9 dummy addr", ay * 16 + ax, 0);
        for (int k = 0; k < 1024; k++) begin
            hread(rd, ax, ay);
            check("R9 R8 readback", rd, int'(pat(k)));
        end

        // R9 dummy read after a pointer set
        reg_write(3'd0, 4'd3);
        reg_write(3'd1, 4'd5);
        reg_write(3'd2, 4'd0);
        hread(rd, ax, ay);
        hread(rd, ax, ay);
        check("R9 second read", rd, int'(pat(5 * 16 + 3)));
        hread(rd, ax, ay);
        check("R9 third read", rd, int'(pat(5 * 16 + 4)));

        // R8 write-only stepping: reads hold the address
        reg_write(3'd4, 4'b0111);
        hread(rd, ax, ay);
        check("R8 read1 addr", ay * 16 + ax, 0);
        hread(rd, ax, ay);
        check("R8 read2 addr", ay * 16 + ax, 0);
        hwrite(8'h11, ax, ay, wd, we);
        check("R8 write addr", ay * 16 + ax, 0);
        hwrite(8'h22, ax, ay, wd, we);
        check("R8 write steps", ay * 16 + ax, 1);

        // R2 strobe in the busy cycle is ignored
        @(negedge clk);
        host_wr = 1'b1;
        @(negedge clk);
        #1;
        check("R2 busy no we", int'(ram_we), 0);
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule